// File: doc/BRIEF.md
# Burst-of-two DDR common-I/O SRAM

This block is a synthesizable model of a small synchronous SRAM with one shared double-data-rate data bus and a fixed burst of two beats. On each rising clock edge the block samples a load strobe, a read/write select and an address. A write command is followed by two data beats, on the next rising edge and the falling edge after it. Each beat carries its own byte-lane enables. The two beats are gathered into one array word twice the bus width, and that word is written in a single operation.

A read fetches one double-width word. The block drives its lower half on a falling edge two and a half cycles after the command, then its upper half on the next rising edge. A valid flag marks both beats. A new command can be accepted on every rising edge, so reads and writes overlap in the pipeline. A read that targets a word whose write has not yet reached the array still returns the new data.

The bus width is a parameter, set as a count of 9-bit lanes. The number of double-width words is a power of two.

Top module: `sram_b2_ddr`

## Requirements
- R1: While rst_ni is low, and until a read is accepted after reset, qvld_o is 0.
- R2: A command is accepted only when ld_i is 1 on a rising edge of clk_i. rw_i = 1 selects a read and rw_i = 0 selects a write. When ld_i is 0, no array word changes, no valid output results, and d_i/be_i on the following edges are ignored.
- R3: For a write accepted on rising edge n, beat 0 (d_i, be_i) is sampled on rising edge n+1 and beat 1 on the falling edge that follows it. Beat 0 forms bits [DQ_W-1:0] of the word and beat 1 forms bits [2*DQ_W-1:DQ_W]. Both halves are stored in one array write.
- R4: be_i is active high. be_i[i] gates bits [9i+8:9i] of its beat, so beat 0 drives word lanes 0..LANES-1 and beat 1 drives lanes LANES..2*LANES-1. A lane whose enable is 0 keeps its previous contents.
- R5: For a read accepted on rising edge n, q_o carries the lower half of the word from the falling edge after rising edge n+2 until rising edge n+3. It then carries the upper half until the next falling edge.
- R6: qvld_o is 1 for exactly the two half-cycles in which a read's beats are on q_o, and 0 at all other times.
- R7: A read accepted on the rising edge right after a write to the same address returns the word as merged by that write's byte enables.
- R8: Commands may be accepted on every rising edge, with reads and writes in any mix. Reads on consecutive edges give an unbroken qvld_o, and every read returns the effect of all writes accepted before it.
- R9: addr_i selects one of 2**ADDR_W double-width words, so each address holds two bus beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; both edges transfer data |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_i | input | 1 | Load strobe, 1 = accept a command |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | ADDR_W | Double-width word address |
| d_i | input | LANES*9 | Write data beat |
| be_i | input | LANES | Byte-lane write enables for the current beat |
| q_o | output | LANES*9 | Read data beat |
| qvld_o | output | 1 | High while q_o carries read data |

## Verification
The case where two functions meet in one cycle is a read accepted on the rising edge right after a write to the same address. On that edge the array stores the gathered write word while the read fetches the same entry. The bench provokes this with write-then-read pairs to one address using partial lane enables. It also provokes it inside a run of alternating writes and reads. The returned beats are judged against a shadow word that applies every earlier write, lane by lane, in command order.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;
  localparam int  LANE_W  = 9;
  localparam logic RW_READ = 1'b1;
endpackage

// File: rtl/sram_b2_wr_gather.sv
module sram_b2_wr_gather
  import sram_b2_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int ADDR_W = 4,
  localparam int DQ_W  = LANES * LANE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ld_i,
  input  logic                 rw_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DQ_W-1:0]      d_i,
  input  logic [LANES-1:0]     be_i,
  output logic                 commit_o,
  output logic [ADDR_W-1:0]    commit_addr_o,
  output logic [2*DQ_W-1:0]    commit_data_o,
  output logic [2*LANES-1:0]   commit_be_o
);
  logic              cmd_v;
  logic [ADDR_W-1:0] cmd_addr;
  logic              b0_v;
  logic [ADDR_W-1:0] b0_addr;
  logic [DQ_W-1:0]   b0_data, b1_data;
  logic [LANES-1:0]  b0_be, b1_be;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_v    <= 1'b0;
      cmd_addr <= '0;
      b0_v     <= 1'b0;
      b0_addr  <= '0;
      b0_data  <= '0;
      b0_be    <= '0;
    end else begin
      cmd_v    <= ld_i && (rw_i != RW_READ);
      cmd_addr <= addr_i;
      b0_v     <= cmd_v;
      if (cmd_v) begin
        b0_addr <= cmd_addr;
        b0_data <= d_i;
        b0_be   <= be_i;
      end
    end
  end

  // second beat arrives on the falling edge after the first
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b1_data <= '0;
      b1_be   <= '0;
    end else if (b0_v) begin
      b1_data <= d_i;
      b1_be   <= be_i;
    end
  end

  assign commit_o      = b0_v;
  assign commit_addr_o = b0_addr;
  assign commit_data_o = {b1_data, b0_data};
  assign commit_be_o   = {b1_be, b0_be};

  assert_commit_from_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(ld_i && (rw_i != RW_READ), 2));

  assert_idle_no_commit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> ##1 !commit_o);
endmodule

// File: rtl/sram_b2_array.sv
module sram_b2_array
  import sram_b2_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int ADDR_W = 4,
  localparam int DQ_W  = LANES * LANE_W,
  localparam int WORD_W = 2 * DQ_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic [2*LANES-1:0] wr_be_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [WORD_W-1:0]  rd_data_o
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_word, fwd_word;
  logic              hit;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int l = 0; l < 2 * LANES; l++) begin
        if (wr_be_i[l]) mem[wr_addr_i][l*LANE_W +: LANE_W] <= wr_data_i[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_word = mem[rd_addr_i];
  assign hit     = wr_en_i && (wr_addr_i == rd_addr_i);

  // bypass lanes being written on the same edge as the fetch
  for (genvar l = 0; l < 2 * LANES; l++) begin : g_fwd
    assign fwd_word[l*LANE_W +: LANE_W] = (hit && wr_be_i[l]) ?
        wr_data_i[l*LANE_W +: LANE_W] : rd_word[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_data_o <= fwd_word;
  end

  assert_wr_addr_known_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !$isunknown(wr_addr_i));

  assert_fwd_full_word_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && wr_en_i && (rd_addr_i == wr_addr_i) && (&wr_be_i))
      |=> rd_data_o == $past(wr_data_i));
endmodule

// File: rtl/sram_b2_rd_pipe.sv
module sram_b2_rd_pipe
  import sram_b2_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int ADDR_W = 4,
  localparam int DQ_W  = LANES * LANE_W,
  localparam int WORD_W = 2 * DQ_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              fetch_en_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic [WORD_W-1:0] fetch_data_i,
  output logic [DQ_W-1:0]   q_o,
  output logic              qvld_o
);
  logic              s1_v, s2_v, s3_v, out_v;
  logic [ADDR_W-1:0] s1_addr;
  logic [WORD_W-1:0] s3_word, out_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v    <= 1'b0;
      s1_addr <= '0;
      s2_v    <= 1'b0;
      s3_v    <= 1'b0;
      s3_word <= '0;
    end else begin
      s1_v    <= ld_i && (rw_i == RW_READ);
      s1_addr <= addr_i;
      s2_v    <= s1_v;
      s3_v    <= s2_v;
      s3_word <= fetch_data_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v    <= 1'b0;
      out_word <= '0;
    end else begin
      out_v    <= s3_v;
      out_word <= s3_word;
    end
  end

  assign fetch_en_o   = s1_v;
  assign fetch_addr_o = s1_addr;
  // low phase shows beat 0, following high phase shows beat 1
  assign q_o    = clk_i ? out_word[WORD_W-1:DQ_W] : out_word[DQ_W-1:0];
  assign qvld_o = out_v;

  assert_read_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && (rw_i == RW_READ)) |=> ##2 qvld_o);

  assert_vld_needs_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qvld_o |-> $past(ld_i && (rw_i == RW_READ), 3));
endmodule

// File: rtl/sram_b2_ddr.sv
module sram_b2_ddr
  import sram_b2_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int ADDR_W = 4,
  localparam int DQ_W  = LANES * LANE_W,
  localparam int WORD_W = 2 * DQ_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   d_i,
  input  logic [LANES-1:0]  be_i,
  output logic [DQ_W-1:0]   q_o,
  output logic              qvld_o
);
  logic               commit;
  logic [ADDR_W-1:0]  commit_addr;
  logic [WORD_W-1:0]  commit_data;
  logic [2*LANES-1:0] commit_be;
  logic               fetch_en;
  logic [ADDR_W-1:0]  fetch_addr;
  logic [WORD_W-1:0]  fetch_data;

  sram_b2_wr_gather #(.LANES(LANES), .ADDR_W(ADDR_W)) u_wr (
    .clk_i, .rst_ni, .ld_i, .rw_i, .addr_i, .d_i, .be_i,
    .commit_o(commit), .commit_addr_o(commit_addr),
    .commit_data_o(commit_data), .commit_be_o(commit_be)
  );

  sram_b2_array #(.LANES(LANES), .ADDR_W(ADDR_W)) u_mem (
    .clk_i, .rst_ni,
    .wr_en_i(commit), .wr_addr_i(commit_addr), .wr_data_i(commit_data), .wr_be_i(commit_be),
    .rd_en_i(fetch_en), .rd_addr_i(fetch_addr), .rd_data_o(fetch_data)
  );

  sram_b2_rd_pipe #(.LANES(LANES), .ADDR_W(ADDR_W)) u_rd (
    .clk_i, .rst_ni, .ld_i, .rw_i, .addr_i,
    .fetch_en_o(fetch_en), .fetch_addr_o(fetch_addr), .fetch_data_i(fetch_data),
    .q_o, .qvld_o
  );
endmodule

// File: tb/sim_sram_b2_ddr.sv
`timescale 1ns/1ps
module sim_sram_b2_ddr;
  localparam int LANES = 2;
  localparam int ADDR_W = 4;
  localparam int DQ_W = LANES * 9;
  localparam int WORD_W = 2 * DQ_W;
  localparam int NOPS = 160;

  logic clk = 1'b0, rst_n = 1'b0, ld = 1'b0, rw = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DQ_W-1:0] d = '0;
  logic [LANES-1:0] be = '0;
  logic [DQ_W-1:0] q;
  logic qvld;

  always #2.5 clk = ~clk;

  sram_b2_ddr #(.LANES(LANES), .ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ld_i(ld), .rw_i(rw), .addr_i(addr),
    .d_i(d), .be_i(be), .q_o(q), .qvld_o(qvld)
  );

  int n_chk = 0, n_bad = 0, cyc = -1, n_ops = 0;
  bit done = 0, mon_done = 0;
  logic              op_ld [NOPS];
  logic              op_rw [NOPS];
  logic [ADDR_W-1:0] op_addr [NOPS];
  logic [DQ_W-1:0]   op_w0 [NOPS], op_w1 [NOPS];
  logic [LANES-1:0]  op_b0 [NOPS], op_b1 [NOPS];
  string             op_tag [NOPS];
  logic [WORD_W-1:0] shadow [1 << ADDR_W];

  int                exp_cyc [$];
  logic [DQ_W-1:0]   exp_lo [$], exp_hi [$];
  string             exp_tag [$];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, logic [DQ_W-1:0] act, logic [DQ_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s cyc=%0d actual=%h expected=%h", tag, what, cyc, act, exp);
    end
  endtask

  function automatic logic [DQ_W-1:0] pat(int k, int s);
    return DQ_W'(k * 2659 + s * 40503 + 17);
  endfunction

  task automatic put(logic l, logic r, int a, logic [DQ_W-1:0] w0, logic [LANES-1:0] b0,
                     logic [DQ_W-1:0] w1, logic [LANES-1:0] b1, string tag);
    op_ld[n_ops] = l; op_rw[n_ops] = r; op_addr[n_ops] = ADDR_W'(a);
    op_w0[n_ops] = w0; op_b0[n_ops] = b0; op_w1[n_ops] = w1; op_b1[n_ops] = b1;
    op_tag[n_ops] = tag;
    n_ops++;
  endtask

  task automatic put_w(int a, logic [LANES-1:0] b0, logic [LANES-1:0] b1);
    put(1'b1, 1'b0, a, pat(n_ops, 1), b0, pat(n_ops, 2), b1, "R3");
  endtask
  task automatic put_r(int a, string tag);
    put(1'b1, 1'b1, a, pat(n_ops, 3), 2'b11, pat(n_ops, 4), 2'b11, tag);
  endtask
  task automatic put_idle(logic r, int a);
    put(1'b0, r, a, pat(n_ops, 5), 2'b11, pat(n_ops, 6), 2'b11, "R2");
  endtask

  task automatic issue(int k);
    if (k < n_ops) begin
      ld = op_ld[k]; rw = op_rw[k]; addr = op_addr[k];
      if (op_ld[k] && op_rw[k]) begin
        exp_cyc.push_back(k);
        exp_lo.push_back(shadow[op_addr[k]][DQ_W-1:0]);
        exp_hi.push_back(shadow[op_addr[k]][WORD_W-1:DQ_W]);
        exp_tag.push_back(op_tag[k]);
      end else if (op_ld[k]) begin
        for (int l = 0; l < LANES; l++) begin
          if (op_b0[k][l]) shadow[op_addr[k]][l*9 +: 9] = op_w0[k][l*9 +: 9];
          if (op_b1[k][l]) shadow[op_addr[k]][DQ_W + l*9 +: 9] = op_w1[k][l*9 +: 9];
        end
      end
    end else begin
      ld = 1'b0; rw = 1'b0; addr = '0;
    end
  endtask

  initial begin
    // R9: fill every word, then read all back on consecutive edges
    for (int a = 0; a < (1 << ADDR_W); a++) put_w(a, 2'b11, 2'b11);
    for (int a = 0; a < (1 << ADDR_W); a++) put_r(a, "R9");
    // R4: partial lanes, including no lanes at all
    put_w(3, 2'b01, 2'b10); put_idle(1'b0, 0);
    put_w(5, 2'b00, 2'b00); put_w(7, 2'b10, 2'b01);
    put_idle(1'b0, 0); put_idle(1'b0, 0);
    put_r(3, "R4"); put_r(5, "R4"); put_r(7, "R4");
    // R7: read right after write to same word
    put_w(9, 2'b01, 2'b11); put_r(9, "R7"); put_idle(1'b0, 0);
    put_w(9, 2'b11, 2'b11); put_r(9, "R7");
    put_w(10, 2'b10, 2'b00); put_r(10, "R7"); put_r(10, "R7");
    put_w(11, 2'b00, 2'b01); put_idle(1'b1, 11); put_r(11, "R7");
    // R2: strobe low with write/read select and junk beats
    put_idle(1'b0, 2); put_idle(1'b1, 2); put_idle(1'b0, 2); put_idle(1'b0, 2);
    put_r(2, "R2");
    // R8: alternating write/read every edge
    for (int i = 0; i < 12; i++) begin
      put_w(12 + (i % 4), LANES'(i % 3 + 1), LANES'((i + 1) % 4));
      put_r(12 + ((i + (i % 2)) % 4), "R8");
    end
    for (int i = 0; i < 6; i++) put_idle(1'b0, 0);
  end

  // driver
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(qvld === 1'b0, "R1", "qvld in reset", DQ_W'(qvld), '0);
    issue(0);
    rst_n = 1'b1;
    for (int j = 0; j < n_ops + 4; j++) begin
      @(posedge clk); #1;
      issue(j + 1);
      if (j >= 1 && j - 1 < n_ops) begin d = op_w1[j-1]; be = op_b1[j-1]; end
      else begin d = pat(j, 7); be = 2'b11; end
      @(negedge clk); #1;
      if (j < n_ops) begin d = op_w0[j]; be = op_b0[j]; end
      else begin d = pat(j, 8); be = 2'b11; end
    end
    done = 1;
  end

  // monitor / scoreboard
  initial begin
    bit ev;
    @(posedge clk); wait (cyc == 0);
    while (!done) begin
      @(negedge clk); #1.25;
      ev = exp_cyc.size() > 0 && exp_cyc[0] + 2 == cyc;
      chk(qvld === ev, "R6", "qvld beat0 phase", DQ_W'(qvld), DQ_W'(ev));
      if (ev) chk(q === exp_lo[0], exp_tag[0], "beat0 (R5)", q, exp_lo[0]);
      @(posedge clk); #1.25;
      ev = exp_cyc.size() > 0 && exp_cyc[0] + 3 == cyc;
      chk(qvld === ev, "R6", "qvld beat1 phase", DQ_W'(qvld), DQ_W'(ev));
      if (ev) begin
        chk(q === exp_hi[0], exp_tag[0], "beat1 (R5)", q, exp_hi[0]);
        void'(exp_cyc.pop_front()); void'(exp_lo.pop_front());
        void'(exp_hi.pop_front()); void'(exp_tag.pop_front());
      end
    end
    chk(exp_cyc.size() == 0, "R5", "reads left unanswered",
        DQ_W'(exp_cyc.size()), '0);
    mon_done = 1;
  end

  initial begin
    fork
      wait (mon_done);
      begin
        #20000;
        n_chk++; n_bad++;
        $display("FAIL R8 watchdog expired actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule